// File: doc/BRIEF.md
# Converter Calibration Coefficient Store

This block keeps the offset and gain correction words for two converter channels, a primary one and an auxiliary one. Software reads and writes them through a small single-cycle register bus. The converter side can load a fresh coefficient when one of its calibration runs completes. Each word comes out of reset with a per-channel default that is set by a parameter.

Software writes are guarded. A coefficient write is accepted only when the converter is enabled and has stayed idle without a break for a minimum dwell time. That time is measured by an idle timer running on the system clock. The cycle count is derived from a clock-frequency parameter and a dwell-time parameter, rounded up. A coefficient write that arrives outside that window is dropped, and a sticky error flag is set. Software clears the flag by writing a 1 to the status word. When a hardware load and a software write target the same word in the same cycle, the hardware value is kept.

Register index: `2*channel + kind`, where kind 0 is offset and kind 1 is gain. With the default of two channels, addresses 0 to 3 are the coefficients (0 = primary offset, 1 = primary gain, 2 = auxiliary offset, 3 = auxiliary gain). Address 4 is the status word, and bit 0 of it is the error flag. Higher addresses are unmapped.

Top module: `adc_cal_regs`

## Requirements
- R1: After reset, address 2*c reads the offset default of channel c, address 2*c+1 reads the gain default of channel c, and the error flag and status word read 0.
- R2: `rdata_o` returns the stored word for the current `addr_i` combinationally, whatever the state of the converter inputs.
- R3: A coefficient write is stored at the clock edge where it is presented if, at that edge, `conv_en_i` and `conv_idle_i` are high and the idle timer has counted IDLE_CYC = ceil(CLK_MHZ*IDLE_NS/1000) consecutive idle-and-enabled edges. The error flag is not set.
- R4: A coefficient write presented while `conv_en_i` is low is discarded, and `wr_err_o` is set at that edge.
- R5: A coefficient write presented after only IDLE_CYC-1 consecutive idle-and-enabled edges is discarded, and `wr_err_o` is set.
- R6: The idle timer restarts from zero at any edge where `conv_en_i` or `conv_idle_i` is low, so a single non-idle cycle forces a full new dwell.
- R7: When `cal_valid_i` is high, the word at index `cal_idx_i` takes `cal_data_i` at that edge, regardless of the enable, idle or guard state.
- R8: When a hardware load and an accepted software write hit the same word in one cycle, the hardware value is stored and no error is raised. Writes and loads to different words both take effect.
- R9: `wr_err_o` stays set until a write to the status address with data bit 0 = 1. A status write with bit 0 = 0 leaves it set. Status writes are not guarded.
- R10: Writes to addresses above the status address change nothing and raise no error, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Bus write strobe |
| addr_i | input | ADDR_W | Word address (3 by default) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| conv_en_i | input | 1 | Converter enabled |
| conv_idle_i | input | 1 | Converter in idle mode |
| cal_valid_i | input | 1 | Calibration result strobe |
| cal_idx_i | input | IDX_W | Target word of the calibration result (2 by default) |
| cal_data_i | input | 16 | Calibration result |
| wr_err_o | output | 1 | Sticky rejected-write flag |

## Verification
The bench uses two channels with distinct defaults in all four words, so a swapped or misindexed reset value is visible. It sets CLK_MHZ = 1 and IDLE_NS = 5000, which shrinks the dwell threshold to five cycles. That makes the exact reject/accept boundary at four and five idle edges reachable in a short run, along with the timer restart after a one-cycle break in idle. The small threshold also leaves room for same-cycle collisions between hardware loads and software writes, and for writes to an unmapped address.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
  localparam int unsigned COEF_W = 16;
  typedef logic [COEF_W-1:0] coef_t;
  typedef enum logic {KIND_OFS = 1'b0, KIND_GAIN = 1'b1} coef_kind_e;
endpackage

// File: rtl/adc_cal_idle_timer.sv
// Counts consecutive enabled-and-idle edges, saturating at IDLE_CYC (>= 1).
module adc_cal_idle_timer #(
  parameter int unsigned IDLE_CYC = 2300,
  parameter int unsigned CNT_W    = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_en_i,
  input  logic             conv_idle_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ready_o
);
  logic quiet;
  assign quiet = conv_en_i & conv_idle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_o <= '0;
    else if (!quiet)                       cnt_o <= '0;
    else if (cnt_o != CNT_W'(IDLE_CYC))    cnt_o <= cnt_o + 1'b1;
  end

  // guard also needs the present cycle to be quiet
  assign ready_o = quiet && (cnt_o == CNT_W'(IDLE_CYC));
endmodule

// File: rtl/adc_cal_coef_reg.sv
module adc_cal_coef_reg
  import adc_cal_pkg::*;
#(
  parameter coef_t RST_VAL = '0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sw_we_i,
  input  coef_t sw_data_i,
  input  logic  hw_we_i,
  input  coef_t hw_data_i,
  output coef_t q_o
);
  // hardware calibration result has priority
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= RST_VAL;
    else if (hw_we_i)  q_o <= hw_data_i;
    else if (sw_we_i)  q_o <= sw_data_i;
  end
endmodule

// File: rtl/adc_cal_regs.sv
module adc_cal_regs
  import adc_cal_pkg::*;
#(
  parameter int unsigned NUM_CH  = 2,
  parameter int unsigned CLK_MHZ = 100,
  parameter int unsigned IDLE_NS = 23000,
  parameter logic [NUM_CH*COEF_W-1:0] OFS_RST  = '0,
  parameter logic [NUM_CH*COEF_W-1:0] GAIN_RST = {NUM_CH{16'h8000}},
  localparam int unsigned NUM_REG  = 2 * NUM_CH,
  localparam int unsigned IDX_W    = $clog2(NUM_REG),
  localparam int unsigned ADDR_W   = IDX_W + 1,
  localparam int unsigned IDLE_CYC = (CLK_MHZ * IDLE_NS + 999) / 1000,
  localparam int unsigned CNT_W    = $clog2(IDLE_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [COEF_W-1:0] wdata_i,
  output logic [COEF_W-1:0] rdata_o,
  input  logic              conv_en_i,
  input  logic              conv_idle_i,
  input  logic              cal_valid_i,
  input  logic [IDX_W-1:0]  cal_idx_i,
  input  logic [COEF_W-1:0] cal_data_i,
  output logic              wr_err_o
);
  logic [CNT_W-1:0]          idle_cnt;
  logic                      wr_ready;
  logic                      coef_sel, stat_sel;
  coef_t                     coef_q [NUM_REG];
  logic [NUM_REG*COEF_W-1:0] coef_flat;

  adc_cal_idle_timer #(
    .IDLE_CYC (IDLE_CYC),
    .CNT_W    (CNT_W)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .conv_en_i   (conv_en_i),
    .conv_idle_i (conv_idle_i),
    .cnt_o       (idle_cnt),
    .ready_o     (wr_ready)
  );

  assign coef_sel = wr_en_i && (addr_i <  ADDR_W'(NUM_REG));
  assign stat_sel = wr_en_i && (addr_i == ADDR_W'(NUM_REG));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    for (genvar k = 0; k < 2; k++) begin : g_kind
      localparam int unsigned IDX = 2 * ch + k;
      localparam coef_t RV = (k == int'(KIND_OFS)) ? OFS_RST[ch*COEF_W +: COEF_W]
                                                   : GAIN_RST[ch*COEF_W +: COEF_W];
      logic sw_we, hw_we;
      assign sw_we = coef_sel && wr_ready && (addr_i[IDX_W-1:0] == IDX_W'(IDX));
      assign hw_we = cal_valid_i && (cal_idx_i == IDX_W'(IDX));

      adc_cal_coef_reg #(.RST_VAL(RV)) u_coef (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sw_we_i   (sw_we),
        .sw_data_i (wdata_i),
        .hw_we_i   (hw_we),
        .hw_data_i (cal_data_i),
        .q_o       (coef_q[IDX])
      );
      assign coef_flat[IDX*COEF_W +: COEF_W] = coef_q[IDX];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        wr_err_o <= 1'b0;
    else if (coef_sel && !wr_ready)     wr_err_o <= 1'b1;
    else if (stat_sel && wdata_i[0])    wr_err_o <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i < ADDR_W'(NUM_REG))       rdata_o = coef_q[addr_i[IDX_W-1:0]];
    else if (addr_i == ADDR_W'(NUM_REG)) rdata_o[0] = wr_err_o;
  end
endmodule

// File: rtl/adc_cal_regs_chk.sv
module adc_cal_regs_chk #(
  parameter int unsigned NUM_REG  = 4,
  parameter int unsigned IDX_W    = 2,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned IDLE_CYC = 2300
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic                  stat_clr_i,
  input logic                  conv_en_i,
  input logic                  conv_idle_i,
  input logic                  cal_valid_i,
  input logic [IDX_W-1:0]      cal_idx_i,
  input logic [15:0]           cal_data_i,
  input logic                  wr_err_o,
  input logic [CNT_W-1:0]      idle_cnt_i,
  input logic [NUM_REG*16-1:0] coef_i
);
  logic [IDX_W-1:0] cal_idx_q;
  logic [15:0]      cal_data_q;
  logic             coef_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cal_idx_q  <= '0;
      cal_data_q <= '0;
    end else begin
      cal_idx_q  <= cal_idx_i;
      cal_data_q <= cal_data_i;
    end
  end

  assign coef_wr = wr_en_i && (addr_i < ADDR_W'(NUM_REG));

  // R4
  rej_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_wr && !conv_en_i |=> wr_err_o);

  // R5
  rej_early_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_wr && (idle_cnt_i < CNT_W'(IDLE_CYC)) |=> wr_err_o);

  // R6
  timer_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(conv_en_i && conv_idle_i) |=> idle_cnt_i == '0);

  // R7
  cal_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_valid_i |=> coef_i[16*cal_idx_q +: 16] == cal_data_q);

  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o && !(wr_en_i && (addr_i == ADDR_W'(NUM_REG)) && stat_clr_i) |=> wr_err_o);

  // R10
  coef_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cal_valid_i && !coef_wr |=> $stable(coef_i));
endmodule

bind adc_cal_regs adc_cal_regs_chk #(
  .NUM_REG  (NUM_REG),
  .IDX_W    (IDX_W),
  .ADDR_W   (ADDR_W),
  .CNT_W    (CNT_W),
  .IDLE_CYC (IDLE_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .addr_i      (addr_i),
  .stat_clr_i  (wdata_i[0]),
  .conv_en_i   (conv_en_i),
  .conv_idle_i (conv_idle_i),
  .cal_valid_i (cal_valid_i),
  .cal_idx_i   (cal_idx_i),
  .cal_data_i  (cal_data_i),
  .wr_err_o    (wr_err_o),
  .idle_cnt_i  (idle_cnt),
  .coef_i      (coef_flat)
);

// File: tb/adc_cal_regs_tb.sv
module adc_cal_regs_tb;
  localparam int unsigned N = 5; // CLK_MHZ=1, IDLE_NS=5000

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        conv_en_i = 1'b0;
  logic        conv_idle_i = 1'b0;
  logic        cal_valid_i = 1'b0;
  logic [1:0]  cal_idx_i = '0;
  logic [15:0] cal_data_i = '0;
  logic        wr_err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0]  addr;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  adc_cal_regs #(
    .NUM_CH   (2),
    .CLK_MHZ  (1),
    .IDLE_NS  (5000),
    .OFS_RST  ({16'h0200, 16'h0100}),
    .GAIN_RST ({16'h8200, 16'h8100})
  ) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .conv_en_i   (conv_en_i),
    .conv_idle_i (conv_idle_i),
    .cal_valid_i (cal_valid_i),
    .cal_idx_i   (cal_idx_i),
    .cal_data_i  (cal_data_i),
    .wr_err_o    (wr_err_o)
  );

  // monitor: pops one expected read per cycle
  item_t it;
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        n_chk++;
        if (rdata_o !== it.exp) begin
          n_fail++;
          $display("FAIL %s: addr %0d rdata %h expected %h", it.tag, it.addr, rdata_o, it.exp);
        end
      end
    end
  end

  // all tasks start and end at a negedge
  task automatic rd(input logic [2:0] a, input logic [15:0] e, input string tag);
    addr_i = a;
    sb_q.push_back('{a, e, tag});
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic cal(input logic [1:0] i, input logic [15:0] d,
                     input bit with_wr, input logic [2:0] a, input logic [15:0] wd);
    cal_valid_i = 1'b1; cal_idx_i = i; cal_data_i = d;
    wr_en_i = with_wr; addr_i = a; wdata_i = wd;
    @(negedge clk);
    cal_valid_i = 1'b0; wr_en_i = 1'b0;
  endtask

  task automatic go_idle(input int n);
    conv_idle_i = 1'b0;
    @(negedge clk);
    conv_idle_i = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_err(input logic e, input string tag);
    n_chk++;
    if (wr_err_o !== e) begin
      n_fail++;
      $display("FAIL %s: wr_err_o %b expected %b", tag, wr_err_o, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset values
    chk_err(1'b0, "R1");
    rd(3'd0, 16'h0100, "R1");
    rd(3'd1, 16'h8100, "R1");
    rd(3'd2, 16'h0200, "R1");
    rd(3'd3, 16'h8200, "R1");
    rd(3'd4, 16'h0000, "R1");

    // R4 disabled converter
    conv_idle_i = 1'b1;
    repeat (10) @(negedge clk);
    wr(3'd0, 16'hDEAD);
    chk_err(1'b1, "R4");
    rd(3'd0, 16'h0100, "R4");

    // R9 sticky, W1C
    wr(3'd4, 16'h0000);
    chk_err(1'b1, "R9");
    wr(3'd4, 16'h0001);
    chk_err(1'b0, "R9");

    // R5 boundary: N-1 rejected
    conv_en_i = 1'b1;
    go_idle(N - 1);
    wr(3'd1, 16'hAAAA);
    chk_err(1'b1, "R5");
    rd(3'd1, 16'h8100, "R5");
    wr(3'd4, 16'h0001);

    // R3 boundary: N accepted
    go_idle(N);
    wr(3'd1, 16'h1234);
    chk_err(1'b0, "R3");
    rd(3'd1, 16'h1234, "R3");

    // R6 one-cycle break restarts dwell
    repeat (N) @(negedge clk);
    conv_idle_i = 1'b0;
    @(negedge clk);
    conv_idle_i = 1'b1;
    repeat (3) @(negedge clk);
    wr(3'd2, 16'h5555);
    chk_err(1'b1, "R6");
    rd(3'd2, 16'h0200, "R6");
    wr(3'd4, 16'h0001);

    // R7 / R2 calibration load while busy and while disabled
    conv_idle_i = 1'b0;
    cal(2'd3, 16'hBEEF, 1'b0, 3'd0, 16'h0000);
    rd(3'd3, 16'hBEEF, "R7 R2");
    conv_en_i = 1'b0;
    cal(2'd0, 16'h0AAA, 1'b0, 3'd0, 16'h0000);
    rd(3'd0, 16'h0AAA, "R7 R2");

    // R8 collision and parallel update
    conv_en_i = 1'b1;
    go_idle(N);
    cal(2'd2, 16'h2222, 1'b1, 3'd2, 16'h1111);
    chk_err(1'b0, "R8");
    rd(3'd2, 16'h2222, "R8");
    cal(2'd1, 16'h9999, 1'b1, 3'd0, 16'h7777);
    rd(3'd0, 16'h7777, "R8");
    rd(3'd1, 16'h9999, "R8");

    // R10 unmapped address
    wr(3'd6, 16'hFFFF);
    chk_err(1'b0, "R10");
    rd(3'd6, 16'h0000, "R10");
    rd(3'd5, 16'h0000, "R10");
    rd(3'd0, 16'h7777, "R10");
    rd(3'd2, 16'h2222, "R10");
    rd(3'd3, 16'hBEEF, "R10");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule